// File: doc/BRIEF.md
# Radix-2 FFT Butterfly Unit

This block computes one radix-2 butterfly per clock on complex fixed-point samples whose real and imaginary parts are 16-bit two's complement. A transform engine feeds it two operands (the even and the odd point), a twiddle factor and three control bits. The control bits choose the decimation ordering, request a conjugated twiddle for inverse transforms, and request a one-bit down-scaling for the stage. Twiddle generation, sample storage and bit-reversed addressing stay in the surrounding engine. The engine may use any power-of-two size. In time decimation the inputs arrive in bit-reversed order, and in frequency decimation the outputs leave in bit-reversed order.

In time-decimation ordering the odd operand is rotated by the twiddle first, then added to and subtracted from the even operand. In frequency-decimation ordering the two operands are added and subtracted first, and only the difference is rotated. A twiddle W = e^(−jπm/n) comes in as Q1.15 parts. The value 1 is represented as 32767 and −1 as −32768.

Both stream edges use valid/ready. An operand set is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is handed over on an edge where `out_valid` and `out_ready` are both high. When a result is waiting and `out_ready` is low, the whole two-stage pipeline freezes. `in_ready` then drops, so no operand set is lost and none is overwritten. Control inputs are sampled together with the operands.

Top module: `fft_bfly`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: With `dif_mode`=0, let t = round(W·odd). Then y0 = (even + t) >>> s and y1 = (even − t) >>> s, where s is the `scale` bit.
- R3: With `dif_mode`=1, y0 = (even + odd) >>> s. Let d = (even − odd) >>> s. Then y1 = round(W·d).
- R4: With `inverse`=1, the imaginary part of W is negated before use, saturating −(−32768) to 32767.
- R5: The scale shift is an arithmetic floor shift by 0 or 1 bit, applied after the add/subtract. Any sum or difference that then falls outside the 16-bit range saturates to 32767 or −32768.
- R6: A complex product uses Q1.15 parts: re = (ar·wr − ai·wi + 2^14) >>> 15 and im = (ar·wi + ai·wr + 2^14) >>> 15. Each part saturates to the 16-bit range.
- R7: An operand set accepted on edge k shows its result with `out_valid`=1 right after edge k+1. Operand sets can be accepted on consecutive edges, and results appear in acceptance order.
- R8: While `out_valid`=1 and `out_ready`=0, the outputs and `out_valid` hold and `in_ready` is 0. When `out_valid`=0, `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Operand set can be taken |
| even_re | input | 16 | Even operand, real part |
| even_im | input | 16 | Even operand, imaginary part |
| odd_re | input | 16 | Odd operand, real part |
| odd_im | input | 16 | Odd operand, imaginary part |
| tw_re | input | 16 | Twiddle real part, Q1.15 |
| tw_im | input | 16 | Twiddle imaginary part, Q1.15 |
| dif_mode | input | 1 | 0 = time decimation, 1 = frequency decimation |
| inverse | input | 1 | Conjugate the twiddle |
| scale | input | 1 | Arithmetic right shift by this many bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| y0_re | output | 16 | First result, real part |
| y0_im | output | 16 | First result, imaginary part |
| y1_re | output | 16 | Second result, real part |
| y1_im | output | 16 | Second result, imaginary part |

## Verification
A result is due two clock cycles after its operands are presented, provided `out_ready` stays high. The bench drives each operand set on a falling edge. It then reads the result on the second falling edge after that, which is after the two registering edges, and checks that `out_valid` drops one cycle later. In the streaming scenario, the result of item i is checked on the same falling edge at which item i+2 is driven. In the stall scenario, the bench holds `out_ready` low for several cycles and compares the outputs each cycle against the first pending result. It then releases `out_ready` and expects the second result on the very next cycle.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  localparam int FBF_DW = 16;
  localparam int FBF_AW = FBF_DW + 2;

  typedef struct packed {
    logic signed [FBF_DW-1:0] re;
    logic signed [FBF_DW-1:0] im;
  } fbf_cplx_t;

  // clamp a value carrying two guard bits into the sample range
  function automatic logic signed [FBF_DW-1:0] fbf_sat(input logic signed [FBF_AW-1:0] v);
    logic [FBF_AW-FBF_DW:0] top;
    top = v[FBF_AW-1:FBF_DW-1];
    if ((&top) || !(|top)) return v[FBF_DW-1:0];
    else if (v[FBF_AW-1])  return {1'b1, {(FBF_DW-1){1'b0}}};
    else                   return {1'b0, {(FBF_DW-1){1'b1}}};
  endfunction
endpackage

// File: rtl/fbf_cmul.sv
module fbf_cmul
  import fbf_pkg::*;
(
  input  fbf_cplx_t a,
  input  fbf_cplx_t w,
  output fbf_cplx_t p
);
  localparam int PW = 2 * FBF_DW + 1;
  localparam int FR = FBF_DW - 1;

  logic signed [PW-1:0] ar, ai, wr, wi, re_acc, im_acc;
  logic signed [PW-1:0] half;

  always_comb begin
    ar     = PW'(a.re);
    ai     = PW'(a.im);
    wr     = PW'(w.re);
    wi     = PW'(w.im);
    half   = PW'(1) <<< (FR - 1);
    re_acc = ar * wr - ai * wi + half;
    im_acc = ar * wi + ai * wr + half;
    p.re   = fbf_sat(re_acc[FR+FBF_AW-1:FR]);
    p.im   = fbf_sat(im_acc[FR+FBF_AW-1:FR]);
  end
endmodule

// File: rtl/fbf_addsub.sv
module fbf_addsub
  import fbf_pkg::*;
(
  input  fbf_cplx_t a,
  input  fbf_cplx_t b,
  input  logic      sh,
  output fbf_cplx_t sum,
  output fbf_cplx_t dif
);
  localparam int EW = FBF_AW;

  logic signed [EW-1:0] sr, si, dr, di;

  always_comb begin
    sr = (EW'(a.re) + EW'(b.re)) >>> sh;
    si = (EW'(a.im) + EW'(b.im)) >>> sh;
    dr = (EW'(a.re) - EW'(b.re)) >>> sh;
    di = (EW'(a.im) - EW'(b.im)) >>> sh;
    sum.re = fbf_sat(sr);
    sum.im = fbf_sat(si);
    dif.re = fbf_sat(dr);
    dif.im = fbf_sat(di);
  end
endmodule

// File: rtl/fft_bfly.sv
module fft_bfly
  import fbf_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [FBF_DW-1:0] even_re,
  input  logic signed [FBF_DW-1:0] even_im,
  input  logic signed [FBF_DW-1:0] odd_re,
  input  logic signed [FBF_DW-1:0] odd_im,
  input  logic signed [FBF_DW-1:0] tw_re,
  input  logic signed [FBF_DW-1:0] tw_im,
  input  logic                     dif_mode,
  input  logic                     inverse,
  input  logic                     scale,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [FBF_DW-1:0] y0_re,
  output logic signed [FBF_DW-1:0] y0_im,
  output logic signed [FBF_DW-1:0] y1_re,
  output logic signed [FBF_DW-1:0] y1_im
);
  logic      adv;
  fbf_cplx_t ev, od, w_eff, rot0, sum0, dif0;
  fbf_cplx_t s1_a, s1_b, s1_w, sum1, dif1, rot1;
  logic      s1_v, s1_dif, s1_sh;
  fbf_cplx_t o0, o1;

  // whole pipe moves unless a finished result is being held
  assign adv      = out_ready || !out_valid;
  assign in_ready = adv;

  // stage 0: conjugate twiddle on request, then front half of either ordering
  always_comb begin
    ev.re    = even_re;
    ev.im    = even_im;
    od.re    = odd_re;
    od.im    = odd_im;
    w_eff.re = tw_re;
    w_eff.im = inverse ? fbf_sat(-FBF_AW'(tw_im)) : tw_im;
  end

  fbf_cmul   u_rot0 (.a(od), .w(w_eff), .p(rot0));
  fbf_addsub u_as0  (.a(ev), .b(od), .sh(scale), .sum(sum0), .dif(dif0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
    end else if (adv) begin
      s1_v <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s1_a   <= dif_mode ? sum0 : ev;
      s1_b   <= dif_mode ? dif0 : rot0;
      s1_w   <= w_eff;
      s1_dif <= dif_mode;
      s1_sh  <= scale;
    end
  end

  // stage 1: back half of either ordering
  fbf_addsub u_as1  (.a(s1_a), .b(s1_b), .sh(s1_sh), .sum(sum1), .dif(dif1));
  fbf_cmul   u_rot1 (.a(s1_b), .w(s1_w), .p(rot1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (adv) begin
      out_valid <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      o0 <= s1_dif ? s1_a : sum1;
      o1 <= s1_dif ? rot1 : dif1;
    end
  end

  assign y0_re = o0.re;
  assign y0_im = o0.im;
  assign y1_re = o1.re;
  assign y1_im = o1.im;
endmodule

// File: rtl/fft_bfly_check.sv
module fft_bfly_check
  import fbf_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic signed [FBF_DW-1:0] y0_re,
  input logic signed [FBF_DW-1:0] y0_im,
  input logic signed [FBF_DW-1:0] y1_re,
  input logic signed [FBF_DW-1:0] y1_im
);
  // R8: a held result keeps its value and its valid flag
  a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(y0_re) && $stable(y0_im)
                                   && $stable(y1_re) && $stable(y1_im)));

  // R8: nothing is taken while a result is blocked
  a_r8_block_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8: an empty output always lets the producer in
  a_r8_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R7: a fresh result follows an acceptance two edges earlier
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready, 2));
endmodule

bind fft_bfly fft_bfly_check u_fft_bfly_check (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .y0_re(y0_re), .y0_im(y0_im), .y1_re(y1_re), .y1_im(y1_im)
);

// File: tb/fft_bfly_test.sv
module fft_bfly_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] even_re = '0, even_im = '0, odd_re = '0, odd_im = '0;
  logic signed [15:0] tw_re = '0, tw_im = '0;
  logic dif_mode = 1'b0, inverse = 1'b0, scale = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [15:0] y0_re, y0_im, y1_re, y1_im;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fft_bfly uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .even_re(even_re), .even_im(even_im), .odd_re(odd_re), .odd_im(odd_im),
    .tw_re(tw_re), .tw_im(tw_im), .dif_mode(dif_mode), .inverse(inverse),
    .scale(scale), .out_valid(out_valid), .out_ready(out_ready),
    .y0_re(y0_re), .y0_im(y0_im), .y1_re(y1_re), .y1_im(y1_im)
  );

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic void cm(input int ar, ai, wr, wi, output int pr, pi);
    longint r, i;
    r = longint'(ar) * wr - longint'(ai) * wi + 16384;
    i = longint'(ar) * wi + longint'(ai) * wr + 16384;
    pr = sat16(r >>> 15);
    pi = sat16(i >>> 15);
  endfunction

  function automatic void model(input int er, ei, orr, oi, wr, wi,
                                input bit dif, inv, sh,
                                output int a, b, c, d);
    int tr, ti, dr, di, w2;
    w2 = inv ? sat16(-longint'(wi)) : wi;
    if (!dif) begin
      cm(orr, oi, wr, w2, tr, ti);
      a = sat16((er + tr) >>> sh);
      b = sat16((ei + ti) >>> sh);
      c = sat16((er - tr) >>> sh);
      d = sat16((ei - ti) >>> sh);
    end else begin
      a  = sat16((er + orr) >>> sh);
      b  = sat16((ei + oi) >>> sh);
      dr = sat16((er - orr) >>> sh);
      di = sat16((ei - oi) >>> sh);
      cm(dr, di, wr, w2, c, d);
    end
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int er, ei, orr, oi, wr, wi, input bit dif, inv, sh);
    even_re = 16'(er); even_im = 16'(ei);
    odd_re = 16'(orr); odd_im = 16'(oi);
    tw_re = 16'(wr); tw_im = 16'(wi);
    dif_mode = dif; inverse = inv; scale = sh;
    in_valid = 1'b1;
  endtask

  task automatic chk_out(input string req, input int a, b, c, d);
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " y0re"}, int'(y0_re), a);
    chk({req, " y0im"}, int'(y0_im), b);
    chk({req, " y1re"}, int'(y1_re), c);
    chk({req, " y1im"}, int'(y1_im), d);
  endtask

  // one operand set, result read two cycles later, then valid must drop (R7)
  task automatic run_one(input string req, input int er, ei, orr, oi, wr, wi,
                         input bit dif, inv, sh);
    int a, b, c, d;
    model(er, ei, orr, oi, wr, wi, dif, inv, sh, a, b, c, d);
    @(negedge clk);
    out_ready = 1'b1;
    drive(er, ei, orr, oi, wr, wi, dif, inv, sh);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk_out(req, a, b, c, d);
    @(negedge clk);
    chk("R7 valid drops", int'(out_valid), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_dit;
    run_one("R2 W(1,0)", 1000, -2000, 300, 400, 32767, 0, 0, 0, 0);
    run_one("R2 W(2,1)", 1200, 700, -500, 900, 0, -32768, 0, 0, 0);
    run_one("R2 W(4,1)", -300, 250, 4000, -1000, 23170, -23170, 0, 0, 0);
    run_one("R2 W(4,3)", 50, 60, 1000, 2000, -23170, -23170, 0, 0, 0);
  endtask

  task automatic t_dif;
    run_one("R3 W(2,0)", 1000, -2000, 300, 400, 32767, 0, 1, 0, 0);
    run_one("R3 W(4,2)", 1500, 200, -700, 800, 0, -32768, 1, 0, 0);
    run_one("R3 W(4,1)", 9000, -4000, 1000, 3000, 23170, -23170, 1, 0, 1);
  endtask

  task automatic t_inverse;
    run_one("R4 DIT conj", 100, 200, 3000, -1000, 23170, -23170, 0, 1, 0);
    run_one("R4 DIF conj", 100, 200, 3000, -1000, 0, -32768, 1, 1, 0);
  endtask

  task automatic t_scale;
    run_one("R5 floor shift", -3, 5, 0, 0, 32767, 0, 0, 0, 1);
    run_one("R5 sum saturates", 30000, -30000, 30000, -30000, 32767, 0, 0, 0, 0);
    run_one("R5 shift avoids sat", 30000, -30000, 30000, -30000, 32767, 0, 1, 0, 1);
  endtask

  task automatic t_round;
    run_one("R6 half rounds up", 0, 0, 1, -1, 16384, 0, 0, 0, 0);
    run_one("R6 product sat", 0, 0, -32768, 0, 0, -32768, 0, 0, 0);
  endtask

  // back-to-back items; item i checked when item i+2 is driven (R7)
  task automatic t_stream;
    int er[6], oi[6], ex[6][4];
    for (int i = 0; i < 6; i++) begin
      er[i] = 500 * i - 1200;
      oi[i] = 777 - 300 * i;
      model(er[i], 10, 200, oi[i], 23170, -23170, i[0], 0, i[1], ex[i][0], ex[i][1], ex[i][2], ex[i][3]);
    end
    out_ready = 1'b1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (c >= 2) chk_out("R7 stream", ex[c-2][0], ex[c-2][1], ex[c-2][2], ex[c-2][3]);
      if (c < 6) drive(er[c], 10, 200, oi[c], 23170, -23170, c[0], 0, c[1]);
      else in_valid = 1'b0;
    end
    @(negedge clk);
    chk("R7 stream drained", int'(out_valid), 0);
  endtask

  task automatic t_stall;
    int a0, b0, c0, d0, a1, b1, c1, d1;
    model(1000, 0, 100, 0, 32767, 0, 0, 0, 0, a0, b0, c0, d0);
    model(-400, 900, 50, -60, 0, -32768, 1, 0, 0, a1, b1, c1, d1);
    @(negedge clk);
    out_ready = 1'b0;
    drive(1000, 0, 100, 0, 32767, 0, 0, 0, 0);
    @(negedge clk);
    drive(-400, 900, 50, -60, 0, -32768, 1, 0, 0);
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk_out("R8 held", a0, b0, c0, d0);
      chk("R8 in_ready low", int'(in_ready), 0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk_out("R8 second after release", a1, b1, c1, d1);
    @(negedge clk);
    chk("R8 drained", int'(out_valid), 0);
    chk("R8 ready when empty", int'(in_ready), 1);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dit();
    t_dif();
    t_inverse();
    t_scale();
    t_round();
    t_stream();
    t_stall();
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule